// File: doc/BRIEF.md
# Packed Sample Widener

This block takes a stream of beats, each holding several narrow samples packed side by side, and widens every sample into a 16-bit or 32-bit slot of an output beat. The narrow sample sits in the low bits of its slot, and lanes keep their positions: lane 0 of the input is lane 0 of the output.

Two runtime controls decide how the upper bits of each slot are filled. With extension off, the upper bits are zero. With extension on, the input is read either as two's complement, where the sign bit is copied upward, or as offset binary, where the sample's top bit is first inverted to give two's complement and the result is then sign extended. The controls are taken together with the beat at the moment it is accepted.

Both sides use a valid/ready handshake. A single output register holds one beat. Upstream is ready whenever that register is empty or is being drained in the same cycle, so a full-rate stream passes with one cycle of latency.

Top module: `sample_upscaler`

## Requirements
- R1: While reset (rstN low) is held at a clock edge, outValid is 0 after that edge and stays 0 until a beat is accepted.
- R2: A beat accepted with extendEn=0 yields, in each output slot, the raw input sample in the low SAMPLE_W bits and zeros above, whatever offsetBin is.
- R3: A beat accepted with extendEn=1 and offsetBin=0 yields, in each slot, the two's complement value of the sample sign extended to OUT_W bits.
- R4: A beat accepted with extendEn=1 and offsetBin=1 yields, in each slot, the sample with its top bit inverted, then sign extended to OUT_W bits (numerically, the sample minus 2^(SAMPLE_W-1)).
- R5: Input lane k, at bits [k*SAMPLE_W +: SAMPLE_W], is written to output lane k, at bits [k*OUT_W +: OUT_W], for every lane.
- R6: A beat is accepted at a clock edge where inValid and inReady are both 1; after that edge outValid is 1 and outData holds that beat's result.
- R7: inReady is 1 exactly when outValid is 0 or outReady is 1.
- R8: While outValid is 1 and outReady is 0, outValid and outData stay unchanged at the next edge, whatever the input side does.
- R9: Changes of extendEn or offsetBin after a beat is accepted have no effect on the beat already held in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| extendEn | input | 1 | 1: extend by input format; 0: zero fill |
| offsetBin | input | 1 | 1: input is offset binary; 0: two's complement |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block can take an input beat |
| inData | input | LANES*SAMPLE_W | Packed narrow samples, lane 0 in the LSBs |
| outValid | output | 1 | Output register holds a beat |
| outReady | input | 1 | Downstream takes the output beat |
| outData | output | LANES*OUT_W | Packed widened samples, lane 0 in the LSBs |

## Verification
The properties assume that extendEn and offsetBin are meaningful only in the cycle a beat is accepted, and that downstream may hold outReady low for any number of cycles; they make no assumption on inData or inValid while the block is not ready. The stimulus therefore changes the format controls and input data freely every cycle, including during stalls, and the reference model latches the controls only on acceptance. Directed beats place zero, the largest positive, the most negative and all-ones codes into separate lanes under each control setting, so lane order and the sign boundary are both observed.

// File: rtl/upscale_pkg.sv
package upscale_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic load;   // capture a widened beat into the output register
  } upscale_ctrl_t;
endpackage

// File: rtl/upscale_lane.sv
module upscale_lane #(
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 16
) (
  input  logic [SAMPLE_W-1:0] rawSample,
  input  logic                extendEn,
  input  logic                offsetBin,
  output logic [OUT_W-1:0]    wideSample
);
  localparam int PAD_W = OUT_W - SAMPLE_W;
  localparam logic [SAMPLE_W-1:0] TOP_MASK = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] twosSample;
  logic                signBit;

  always_comb begin
    // offset binary becomes two's complement by flipping the top bit
    twosSample = (extendEn && offsetBin) ? (rawSample ^ TOP_MASK) : rawSample;
    signBit    = extendEn & twosSample[SAMPLE_W-1];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign wideSample = {{PAD_W{signBit}}, twosSample};
    end else begin : g_nopad
      assign wideSample = twosSample;
    end
  endgenerate
endmodule

// File: rtl/upscale_datapath.sv
module upscale_datapath
  import upscale_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 16
) (
  input  logic                      clk,
  input  upscale_ctrl_t             ctrl,
  input  logic                      extendEn,
  input  logic                      offsetBin,
  input  logic [LANES*SAMPLE_W-1:0] inData,
  output logic [LANES*OUT_W-1:0]    outData
);
  logic [LANES*OUT_W-1:0] wideBeat;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      upscale_lane #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_lane (
        .rawSample (inData[l*SAMPLE_W +: SAMPLE_W]),
        .extendEn  (extendEn),
        .offsetBin (offsetBin),
        .wideSample(wideBeat[l*OUT_W +: OUT_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ctrl.load) outData <= wideBeat;
  end
endmodule

// File: rtl/upscale_control.sv
module upscale_control
  import upscale_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output upscale_ctrl_t ctrl
);
  logic holdValid;

  always_comb begin
    inReady   = !holdValid || outReady;
    ctrl.load = inValid && inReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          holdValid <= 1'b0;
    else if (ctrl.load) holdValid <= 1'b1;
    else if (outReady)  holdValid <= 1'b0;
  end

  assign outValid = holdValid;
endmodule

// File: rtl/sample_upscaler.sv
module sample_upscaler
  import upscale_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      extendEn,
  input  logic                      offsetBin,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [LANES*SAMPLE_W-1:0] inData,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [LANES*OUT_W-1:0]    outData
);
  generate
    if (!(OUT_W == 16 || OUT_W == 32) || SAMPLE_W > OUT_W || SAMPLE_W < 1 || LANES < 1) begin : g_bad_cfg
      $error("sample_upscaler: OUT_W must be 16 or 32 and SAMPLE_W within 1..OUT_W");
    end
  endgenerate

  upscale_ctrl_t ctrl;

  upscale_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .ctrl    (ctrl)
  );

  upscale_datapath #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .extendEn (extendEn),
    .offsetBin(offsetBin),
    .inData   (inData),
    .outData  (outData)
  );
endmodule

// File: rtl/upscale_checker.sv
module upscale_checker #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      extendEn,
  input logic                      offsetBin,
  input logic                      inValid,
  input logic                      inReady,
  input logic [LANES*SAMPLE_W-1:0] inData,
  input logic                      outValid,
  input logic                      outReady,
  input logic [LANES*OUT_W-1:0]    outData
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> !outValid);

  // R7
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady == (!outValid || outReady));

  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R5
  lane0_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !(extendEn && offsetBin)) |=>
      outData[SAMPLE_W-1:0] == $past(inData[SAMPLE_W-1:0]));

  generate
    if (OUT_W > SAMPLE_W) begin : g_pad_chk
      // R2
      zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && inReady && !extendEn) |=>
          outData[OUT_W-1:SAMPLE_W] == '0);
      // R3
      sign_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && inReady && extendEn) |=>
          outData[OUT_W-1:SAMPLE_W] == {(OUT_W-SAMPLE_W){outData[SAMPLE_W-1]}});
    end
  endgenerate
endmodule

bind sample_upscaler upscale_checker #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/sample_upscaler_tb.sv
module sample_upscaler_tb;
  localparam int LANES = 4;
  localparam int SW    = 12;
  localparam int OW    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extendEn = 1'b0, offsetBin = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic [LANES*SW-1:0] inData = '0;
  logic inReady, outValid;
  logic [LANES*OW-1:0] outData;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit                  expValid = 1'b0;
  logic [LANES*OW-1:0] expData  = '0;
  string               expTag   = "R2";

  always #4 clk = ~clk;

  sample_upscaler #(.LANES(LANES), .SAMPLE_W(SW), .OUT_W(OW)) u_dut (
    .clk(clk), .rstN(rstN), .extendEn(extendEn), .offsetBin(offsetBin),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  function automatic logic [LANES*OW-1:0] widen(logic [LANES*SW-1:0] d, bit ext, bit off);
    logic [LANES*OW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      int s, v;
      s = int'(d[l*SW +: SW]);
      if (!ext)     v = s;
      else if (off) v = s - (1 << (SW - 1));
      else          v = (s >= (1 << (SW - 1))) ? s - (1 << SW) : s;
      r[l*OW +: OW] = OW'(v);
    end
    return r;
  endfunction

  function automatic string tagFor(bit ext, bit off);
    if (!ext) return "R2";
    return off ? "R4" : "R3";
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: compare registered outputs, apply new inputs, predict next edge
  task automatic step(bit iv, logic [LANES*SW-1:0] d, bit ext, bit off, bit ordy);
    @(negedge clk);
    check(outValid == expValid, "R6,R8 outValid", 128'(outValid), 128'(expValid));
    if (expValid)
      check(outData == expData, {expTag, ",R5,R9 outData"}, 128'(outData), 128'(expData));
    inValid = iv; inData = d; extendEn = ext; offsetBin = off; outReady = ordy;
    #1;
    check(inReady == (!expValid || ordy), "R7 inReady", 128'(inReady), 128'(!expValid || ordy));
    if (iv && (!expValid || ordy)) begin
      expValid = 1'b1;
      expData  = widen(d, ext, off);
      expTag   = tagFor(ext, off);
    end else if (ordy) begin
      expValid = 1'b0;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [LANES*SW-1:0] corners;
    corners = {12'hFFF, 12'h800, 12'h7FF, 12'h000};
    // R1: reset with a pending beat on the input
    inValid = 1'b1; inData = corners; outReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset", 128'(outValid), 128'(0));
    rstN = 1'b1;
    inValid = 1'b0;
    // directed corners in every control setting (R2 R3 R4 R5)
    for (int m = 0; m < 4; m++) step(1'b1, corners, m[1], m[0], 1'b1);
    step(1'b1, {12'h001, 12'h801, 12'h7FE, 12'hABC}, 1'b1, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    // R8, R9: stall with controls and data moving underneath
    step(1'b1, corners, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, LANES*SW'(i * 37 + 5), i[0], i[1], 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    // randomised traffic
    for (int i = 0; i < 3000; i++) begin
      logic [LANES*SW-1:0] rd;
      rd = {$urandom, $urandom};
      step(($urandom % 4) != 0, rd, $urandom % 2, $urandom % 2, ($urandom % 3) != 0);
    end
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    // R1: reset again while a beat is held
    step(1'b1, corners, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset mid-run", 128'(outValid), 128'(0));
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule